// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers up to eight one-cycle activity pulses from a serial-bus device into a set of sticky pending bits. Each pending bit is paired with a bit in an enable register. When any pending bit meets a set enable bit, the single active-high interrupt line goes high. Generating the events is the job of other logic.

A host reaches the block through a plain synchronous register port made of an address, a write strobe, write data and read data. The pending bits live at address 0x0D. Writing a 1 to a pending bit clears it, and writing a 0 leaves it as it is. The enable mask lives at address 0x06. This port and the event vector are control and status pins, not streams. There is no valid/ready handshake and no back-pressure: a write takes effect at the clock edge on which its strobe is high, and read data follows the address combinationally.

Top module: `evirq_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the pending bits are 0x00, the enable mask is 0x00 and `intr_o` is low.
- R2: A one-cycle pulse on `evt_i[i]` sets pending bit i at that clock edge. The bit stays set after the pulse ends until the host clears it. A pending bit never sets without an event.
- R3: Pending bits capture events whatever the enable mask holds. The mask only gates `intr_o`.
- R4: A write to address 0x0D clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R5: If an event and a clear hit the same bit at the same clock edge, the bit ends up set.
- R6: Reading address 0x0D returns the pending bits, with bit i for event i. Reading address 0x06 returns the enable mask. Any other address reads as 0x00.
- R7: `intr_o` is a register. One clock after an edge where pending AND mask is non-zero, it is 1. It is 0 one clock after an edge where that AND is zero.
- R8: A write to 0x06 loads the enable mask. A write to any address other than 0x06 and 0x0D changes neither the pending bits nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_EVT | One-cycle event pulses, one per source |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe for the current address |
| reg_wdata | input | N_EVT | Write data |
| reg_rdata | output | N_EVT | Read data for the current address |
| intr_o | output | 1 | Registered interrupt, active high |

## Verification
On every cycle the bound checker checks four things. Events always land in the pending bits, and no bit rises without an event. Pending bits drop only under a clear write, and a clear write empties every bit it targets unless an event hits that bit at the same edge. The mask changes only when its address is written, and the interrupt goes high only when some enabled bit was pending one clock earlier. Other behaviour needs the bench's scenarios to show it: the exact value read back at each address, masking of bits that are pending but disabled, the one-clock latency of the interrupt, and the outcome when a clear and an event collide.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int unsigned EVQ_DEF_EVENTS = 8;
  localparam int unsigned EVQ_DEF_ADDR_W = 8;
  localparam logic [7:0]  EVQ_PEND_ADDR  = 8'h0D;
  localparam logic [7:0]  EVQ_MASK_ADDR  = 8'h06;
endpackage

// File: rtl/evirq_sticky.sv
module evirq_sticky #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] clr,
  output logic [N_EVT-1:0] pend
);
  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (evt[i]) pend[i] <= 1'b1;   // event has priority over clear
      else if (clr[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evirq_maskreg.sv
module evirq_maskreg #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_EVT-1:0] din,
  output logic [N_EVT-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= din;
  end
endmodule

// File: rtl/evirq_combine.sv
module evirq_combine #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] pend,
  input  logic [N_EVT-1:0] mask,
  output logic             intr
);
  logic [N_EVT-1:0] live;
  assign live = pend & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intr <= 1'b0;
    else        intr <= |live;
  end
endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
  import evirq_pkg::*;
#(
  parameter int unsigned N_EVT     = EVQ_DEF_EVENTS,
  parameter int unsigned ADDR_W    = EVQ_DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(EVQ_PEND_ADDR),
  parameter logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(EVQ_MASK_ADDR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [N_EVT-1:0]  reg_wdata,
  output logic [N_EVT-1:0]  reg_rdata,
  output logic              intr_o
);
  logic             hit_pend, hit_mask;
  logic [N_EVT-1:0] clr_vec;
  logic [N_EVT-1:0] pend_q, mask_q;

  assign hit_pend = (reg_addr == PEND_ADDR);
  assign hit_mask = (reg_addr == MASK_ADDR);
  assign clr_vec  = (reg_we && hit_pend) ? reg_wdata : '0;

  evirq_sticky #(.N_EVT(N_EVT)) u_sticky (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .clr(clr_vec), .pend(pend_q)
  );

  evirq_maskreg #(.N_EVT(N_EVT)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(reg_we && hit_mask), .din(reg_wdata), .mask(mask_q)
  );

  evirq_combine #(.N_EVT(N_EVT)) u_comb (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(mask_q), .intr(intr_o)
  );

  always_comb begin
    if (hit_pend)      reg_rdata = pend_q;
    else if (hit_mask) reg_rdata = mask_q;
    else               reg_rdata = '0;
  end
endmodule

// File: rtl/evirq_ctrl_chk.sv
module evirq_ctrl_chk #(
  parameter int unsigned N_EVT  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h0D,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h06
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EVT-1:0]  evt_i,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [N_EVT-1:0]  reg_wdata,
  input logic [N_EVT-1:0]  pend,
  input logic [N_EVT-1:0]  mask,
  input logic              intr_o
);
  // R2: every event is captured
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend & $past(evt_i)) == $past(evt_i)));

  // R2: no bit rises without an event
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt_i)) == '0));

  // R4: without a clear write no pending bit is lost
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == PEND_ADDR) |=> ((pend & $past(pend)) == $past(pend)));

  // R4 and R5: targeted bits drop unless an event hits them
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == PEND_ADDR) |=> ((pend & $past(reg_wdata & ~evt_i)) == '0));

  // R8: mask changes only when its address is written
  p_mask_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == MASK_ADDR) |=> $stable(mask));

  // R7: interrupt only follows an enabled pending bit
  p_intr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> ($past(pend & mask) != '0));
endmodule

bind evirq_ctrl evirq_ctrl_chk #(
  .N_EVT(N_EVT), .ADDR_W(ADDR_W), .PEND_ADDR(PEND_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .pend(pend_q), .mask(mask_q), .intr_o(intr_o)
);

// File: tb/evirq_ctrl_bench.sv
module evirq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic [7:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       intr_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_mask = '0;

  always #4 clk = ~clk;

  evirq_ctrl u_evirq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intr_o(intr_o)
  );

  // {event, write, address, write data, expected pending}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 1'b1, 8'h06, 8'h05, 8'h00},
    {8'h02, 1'b0, 8'h00, 8'h00, 8'h02},
    {8'h04, 1'b0, 8'h00, 8'h00, 8'h06},
    {8'h00, 1'b1, 8'h0D, 8'h04, 8'h02},
    {8'h00, 1'b1, 8'h0D, 8'h00, 8'h02},
    {8'h81, 1'b1, 8'h0D, 8'h02, 8'h81},
    {8'h01, 1'b1, 8'h0D, 8'h01, 8'h81},
    {8'h00, 1'b1, 8'h20, 8'hFF, 8'h81},
    {8'h00, 1'b1, 8'h0D, 8'hFF, 8'h00},
    {8'hFF, 1'b0, 8'h00, 8'h00, 8'hFF},
    {8'h00, 1'b1, 8'h06, 8'h00, 8'hFF},
    {8'h00, 1'b1, 8'h0D, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_read(input logic [7:0] a);
    evt_i = '0; reg_we = 1'b0; reg_wdata = '0; reg_addr = a;
    #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_read(8'h0D); chk("R1 pending in reset", reg_rdata, 8'h00);
    idle_read(8'h06); chk("R1 mask in reset", reg_rdata, 8'h00);
    chk("R1 intr in reset", {7'b0, intr_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 intr after release", {7'b0, intr_o}, 8'h00);

    for (int r = 0; r < NV; r++) begin
      logic [7:0] e, a, d, xp;
      logic w;
      {e, w, a, d, xp} = VEC[r];
      evt_i = e; reg_we = w; reg_addr = a; reg_wdata = d;
      if (w && a == 8'h06) exp_mask = d;
      @(posedge clk); @(negedge clk);
      idle_read(8'h0D);
      chk($sformatf("R2 R3 R4 R5 R8 row %0d pending", r), reg_rdata, xp);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R7 row %0d intr", r), {7'b0, intr_o}, {7'b0, |(xp & exp_mask)});
    end

    // R6 readback and unmapped read
    reg_we = 1'b1; reg_addr = 8'h06; reg_wdata = 8'h3C;
    @(posedge clk); @(negedge clk);
    idle_read(8'h06); chk("R6 mask readback", reg_rdata, 8'h3C);
    idle_read(8'h07); chk("R6 unmapped read", reg_rdata, 8'h00);

    // R8 neighbour write leaves mask
    reg_we = 1'b1; reg_addr = 8'h07; reg_wdata = 8'hFF;
    @(posedge clk); @(negedge clk);
    idle_read(8'h06); chk("R8 mask after other write", reg_rdata, 8'h3C);

    // R7 latency: event at edge k, pending after k, intr after k+1
    evt_i = 8'h10;
    @(posedge clk); @(negedge clk);
    idle_read(8'h0D);
    chk("R3 pending bit 4", reg_rdata, 8'h10);
    chk("R7 intr not yet", {7'b0, intr_o}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R7 intr one clock later", {7'b0, intr_o}, 8'h01);
    // clear it: intr drops one clock after pending drops
    reg_we = 1'b1; reg_addr = 8'h0D; reg_wdata = 8'h10;
    @(posedge clk); @(negedge clk);
    idle_read(8'h0D);
    chk("R4 cleared bit 4", reg_rdata, 8'h00);
    chk("R7 intr still high", {7'b0, intr_o}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R7 intr dropped", {7'b0, intr_o}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule